// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block takes two reference clocks, a primary and a backup, and hands one of them to a downstream phase detector. A free-running sampling clock drives a presence detector for each input. The detector counts rising edges over a fixed window and judges the input valid when the count reaches a threshold. A mode input picks the selection policy. In manual mode an external pick input names the source. In automatic mode the primary wins whenever it is valid, the backup takes over while the primary is missing, and the primary is taken back as soon as it returns.

The handover between the two asynchronous clocks goes through a gate per input. Each gate opens and closes only on its own clock's falling edge, and it opens only after the other gate has shut. Because of this the output carries no runt pulse. A gate whose clock has stopped entirely is cleared from the sampling domain, so a dead clock cannot block the handover. Two status outputs report whether any reference is valid and which input the policy has chosen.

Top module: `refsel_top`

## Requirements
- R1: With `auto_en` low, `man_pick_pri` = 1 routes the primary to `clk_out` and `man_pick_pri` = 0 routes the secondary, provided the chosen input is valid.
- R2: With `auto_en` high and both inputs valid, the primary is routed to `clk_out`.
- R3: With `auto_en` high, a secondary that is valid and a primary that still toggles but is invalid, the secondary is routed to `clk_out`.
- R4: With `auto_en` high, once the primary becomes valid again after an outage, routing returns to the primary.
- R5: An input is valid only when it shows at least `THRESH` rising edges within a window of `WIN` sampling-clock cycles. A slower input counts as invalid.
- R6: `ref_ok` is high exactly when at least one input is valid.
- R7: `pri_active` is 1 when the primary is the chosen source and 0 when the secondary is. It follows the pick input in manual mode. In automatic mode with neither input valid it reports 1. After reset it is 1 and `ref_ok` is 0.
- R8: `clk_out` never carries a high or low phase shorter than half the period of the clock it passes, including across switch-overs. The two gates are never open at the same time.
- R9: When the chosen source is invalid, or neither input is valid, `clk_out` is held low.
- R10: An input with no edges in a full window has its gate cleared without help from its own clock. Failover away from a stopped primary therefore completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Free-running sampling clock for detection and policy |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_pri | input | 1 | Primary reference clock |
| ref_sec | input | 1 | Secondary reference clock |
| auto_en | input | 1 | 1 = automatic primary-preferred selection, 0 = manual |
| man_pick_pri | input | 1 | Manual choice: 1 = primary, 0 = secondary |
| clk_out | output | 1 | Selected reference clock, gated glitch-free |
| ref_ok | output | 1 | High when at least one reference is valid |
| pri_active | output | 1 | High when the primary is chosen, low for the secondary |

## Verification
The bench sweeps every combination of mode and pick input against three primary conditions (in range, toggling too slowly, stopped low) and two secondary conditions (running, stopped). Consecutive cases move through many switch-overs in both directions. The period measured on `clk_out` tells which source is routed, 160 ns for the primary and 190 ns for the secondary, or shows that nothing is routed. The slow-primary cases separate the threshold test from plain edge presence. The stopped-primary cases show that failover does not wait on a dead clock. A final revert step confirms that the primary is reclaimed. A pulse-width monitor records the narrowest phase seen over the whole run.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
  typedef enum logic {
    SRC_SEC = 1'b0,
    SRC_PRI = 1'b1
  } src_e;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned IDX_PRI = 0;
  localparam int unsigned IDX_SEC = 1;
endpackage

// File: rtl/refsel_sync.sv
`timescale 1ns/1ps
module refsel_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/refsel_activity.sv
`timescale 1ns/1ps
module refsel_activity #(
  parameter int unsigned WIN    = 64,
  parameter int unsigned THRESH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic ok,
  output logic dead
);
  localparam int unsigned WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int unsigned CW = $clog2(THRESH + 1);

  logic          ref_s;
  logic          ref_d_q;
  logic          rise;
  logic [WW-1:0] win_q, win_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ok_q, ok_n;
  logic          dead_q, dead_n;
  logic          win_end;

  refsel_sync #(.WIDTH(1), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ref_i),
    .q     (ref_s)
  );

  assign rise    = ref_s & ~ref_d_q;
  assign win_end = (win_q == WW'(WIN - 1));

  always_comb begin
    win_n  = win_end ? '0 : win_q + 1'b1;
    ok_n   = ok_q;
    dead_n = dead_q;
    if (win_end) begin
      ok_n   = (cnt_q == CW'(THRESH));
      dead_n = (cnt_q == '0);
      cnt_n  = '0;
    end else if (rise && (cnt_q != CW'(THRESH))) begin
      cnt_n  = cnt_q + 1'b1;
    end else begin
      cnt_n  = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d_q <= 1'b0;
      win_q   <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      dead_q  <= 1'b1;
    end else begin
      ref_d_q <= ref_s;
      win_q   <= win_n;
      cnt_q   <= cnt_n;
      ok_q    <= ok_n;
      dead_q  <= dead_n;
    end
  end

  assign ok   = ok_q;
  assign dead = dead_q;
endmodule

// File: rtl/refsel_policy.sv
`timescale 1ns/1ps
module refsel_policy
  import refsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_s,
  input  logic man_s,
  input  logic pri_ok,
  input  logic sec_ok,
  output src_e sel,
  output logic req_pri,
  output logic req_sec,
  output logic ref_ok
);
  src_e sel_q, sel_n;
  logic req_pri_q, req_pri_n;
  logic req_sec_q, req_sec_n;
  logic ref_ok_q, ref_ok_n;

  always_comb begin
    if (!auto_s) begin
      sel_n = man_s ? SRC_PRI : SRC_SEC;
    end else if (pri_ok) begin
      sel_n = SRC_PRI;
    end else if (sec_ok) begin
      sel_n = SRC_SEC;
    end else begin
      sel_n = SRC_PRI;
    end
    req_pri_n = (sel_n == SRC_PRI) && pri_ok;
    req_sec_n = (sel_n == SRC_SEC) && sec_ok;
    ref_ok_n  = pri_ok | sec_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= SRC_PRI;
      req_pri_q <= 1'b0;
      req_sec_q <= 1'b0;
      ref_ok_q  <= 1'b0;
    end else begin
      sel_q     <= sel_n;
      req_pri_q <= req_pri_n;
      req_sec_q <= req_sec_n;
      ref_ok_q  <= ref_ok_n;
    end
  end

  assign sel     = sel_q;
  assign req_pri = req_pri_q;
  assign req_sec = req_sec_q;
  assign ref_ok  = ref_ok_q;
endmodule

// File: rtl/refsel_gate.sv
`timescale 1ns/1ps
module refsel_gate (
  input  logic clk_i,
  input  logic clr_n,
  input  logic req,
  input  logic other_en,
  output logic en
);
  logic s1_q, s2_q;

  always_ff @(negedge clk_i or negedge clr_n) begin
    if (!clr_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= req & ~other_en;
      s2_q <= s1_q;
    end
  end

  assign en = s2_q;
endmodule

// File: rtl/refsel_top.sv
`timescale 1ns/1ps
module refsel_top
  import refsel_pkg::*;
#(
  parameter int unsigned WIN    = 64,
  parameter int unsigned THRESH = 4
) (
  input  logic clk_smp,
  input  logic rst_n,
  input  logic ref_pri,
  input  logic ref_sec,
  input  logic auto_en,
  input  logic man_pick_pri,
  output logic clk_out,
  output logic ref_ok,
  output logic pri_active
);
  logic                rst_s_n;
  logic [1:0]          ctl_s;
  logic                auto_s;
  logic                man_s;
  logic [NUM_SRC-1:0]  refs;
  logic [NUM_SRC-1:0]  ok;
  logic [NUM_SRC-1:0]  dead;
  logic [NUM_SRC-1:0]  req;
  logic [NUM_SRC-1:0]  en;
  logic                pri_ok;
  logic                sec_ok;
  src_e                sel;

  refsel_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk   (clk_smp),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_s_n)
  );

  refsel_sync #(.WIDTH(2), .STAGES(2)) u_ctl_sync (
    .clk   (clk_smp),
    .rst_n (rst_s_n),
    .d     ({auto_en, man_pick_pri}),
    .q     (ctl_s)
  );
  assign auto_s = ctl_s[1];
  assign man_s  = ctl_s[0];

  assign refs[IDX_PRI] = ref_pri;
  assign refs[IDX_SEC] = ref_sec;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    refsel_activity #(.WIN(WIN), .THRESH(THRESH)) u_act (
      .clk   (clk_smp),
      .rst_n (rst_s_n),
      .ref_i (refs[gi]),
      .ok    (ok[gi]),
      .dead  (dead[gi])
    );

    refsel_gate u_gate (
      .clk_i    (refs[gi]),
      .clr_n    (~dead[gi]),
      .req      (req[gi]),
      .other_en (en[NUM_SRC-1-gi]),
      .en       (en[gi])
    );
  end

  assign pri_ok = ok[IDX_PRI];
  assign sec_ok = ok[IDX_SEC];

  refsel_policy u_policy (
    .clk     (clk_smp),
    .rst_n   (rst_s_n),
    .auto_s  (auto_s),
    .man_s   (man_s),
    .pri_ok  (pri_ok),
    .sec_ok  (sec_ok),
    .sel     (sel),
    .req_pri (req[IDX_PRI]),
    .req_sec (req[IDX_SEC]),
    .ref_ok  (ref_ok)
  );

  assign pri_active = (sel == SRC_PRI);
  assign clk_out    = |(refs & en);
endmodule

// File: rtl/refsel_chk.sv
`timescale 1ns/1ps
module refsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_s,
  input logic       man_s,
  input logic       pri_ok,
  input logic       sec_ok,
  input logic       pri_active,
  input logic [1:0] en,
  input logic [1:0] dead
);
  assert_gates_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));

  assert_manual_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_s |=> (pri_active == $past(man_s)));

  assert_auto_prefers_pri_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_s && pri_ok) |=> pri_active);

  assert_auto_failover_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_s && !pri_ok && sec_ok) |=> !pri_active);

  assert_dead_pri_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dead[0] |-> !en[0]);

  assert_dead_sec_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dead[1] |-> !en[1]);
endmodule

bind refsel_top refsel_chk u_refsel_chk (
  .clk        (clk_smp),
  .rst_n      (rst_s_n),
  .auto_s     (auto_s),
  .man_s      (man_s),
  .pri_ok     (pri_ok),
  .sec_ok     (sec_ok),
  .pri_active (pri_active),
  .en         (en),
  .dead       (dead)
);

// File: tb/test_refsel_top.sv
`timescale 1ns/1ps
module test_refsel_top;
  logic clk_smp = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pri = 1'b0;
  logic ref_sec = 1'b0;
  logic auto_en = 1'b0;
  logic man_pick_pri = 1'b1;
  logic clk_out, ref_ok, pri_active;

  int checks = 0;
  int fails = 0;
  int pri_mode = 0;   // 0 = 160 ns period, 1 = 600 ns period, 2 = stopped low
  int sec_off = 0;    // 0 = 190 ns period, 1 = stopped low

  realtime last_rise = 0, last_fall = 0, last_per = 0, min_w = 1.0e9;
  int rises = 0;

  refsel_top i_refsel_top (
    .clk_smp(clk_smp), .rst_n(rst_n), .ref_pri(ref_pri), .ref_sec(ref_sec),
    .auto_en(auto_en), .man_pick_pri(man_pick_pri),
    .clk_out(clk_out), .ref_ok(ref_ok), .pri_active(pri_active)
  );

  always #10 clk_smp = ~clk_smp;

  always begin
    if (pri_mode == 2) begin ref_pri = 1'b0; #20; end
    else if (pri_mode == 1) begin #300 ref_pri = ~ref_pri; end
    else begin #80 ref_pri = ~ref_pri; end
  end

  always begin
    if (sec_off != 0) begin ref_sec = 1'b0; #20; end
    else begin #95 ref_sec = ~ref_sec; end
  end

  always @(posedge clk_out) begin
    realtime w;
    w = $realtime - last_fall;
    if (rst_n && last_fall > 0 && w < min_w) min_w = w;
    last_per  = $realtime - last_rise;
    last_rise = $realtime;
    rises++;
  end

  always @(negedge clk_out) begin
    realtime w;
    w = $realtime - last_rise;
    if (rst_n && w < min_w) min_w = w;
    last_fall = $realtime;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // 0 = nothing routed, 1 = primary, 2 = secondary, 3 = unknown period
  task automatic measure(output int src);
    int r0;
    r0 = rises;
    #1500;
    if (rises - r0 < 2) src = 0;
    else if (last_per > 159.0 && last_per < 161.0) src = 1;
    else if (last_per > 189.0 && last_per < 191.0) src = 2;
    else src = 3;
  endtask

  task automatic run_case(input int am, input int pm, input int so, input int sel);
    int pv, sv, exp_pa, exp_src, src;
    string src_tag;
    auto_en = am[0]; pri_mode = pm; sec_off = so; man_pick_pri = sel[0];
    #5000;
    @(negedge clk_smp);
    pv = (pm == 0) ? 1 : 0;
    sv = (so == 0) ? 1 : 0;
    if (am == 0) exp_pa = sel;
    else exp_pa = (pv != 0) ? 1 : ((sv != 0) ? 0 : 1);
    if (exp_pa == 1 && pv != 0) exp_src = 1;
    else if (exp_pa == 0 && sv != 0) exp_src = 2;
    else exp_src = 0;
    if (exp_src == 0) src_tag = "R9 clk_out source";
    else if (am == 0) src_tag = "R1 clk_out source";
    else if (pv != 0) src_tag = "R2 clk_out source";
    else if (pm == 2) src_tag = "R10 clk_out source";
    else src_tag = "R3 clk_out source";
    check((pm == 1) ? "R5 ref_ok" : "R6 ref_ok", int'(ref_ok), (pv | sv));
    check("R7 pri_active", int'(pri_active), exp_pa);
    measure(src);
    check(src_tag, src, exp_src);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int src;
    #95;
    check("R7 reset pri_active", int'(pri_active), 1);
    check("R7 reset ref_ok", int'(ref_ok), 0);
    check("R9 reset clk_out", int'(clk_out), 0);
    #5 rst_n = 1'b1;

    for (int am = 0; am < 2; am++)
      for (int pm = 0; pm < 3; pm++)
        for (int so = 0; so < 2; so++)
          for (int sel = 0; sel < 2; sel++)
            run_case(am, pm, so, sel);

    // R4: outage of the primary, then its return, in automatic mode
    run_case(1, 2, 0, 0);
    auto_en = 1'b1; pri_mode = 0; sec_off = 0;
    #5000;
    @(negedge clk_smp);
    check("R4 pri_active after return", int'(pri_active), 1);
    measure(src);
    check("R4 clk_out source after return", src, 1);

    // R8: narrowest phase seen on clk_out (ns) must be at least 75
    check("R8 min phase >= 75ns", (min_w >= 75.0) ? 1 : 0, 1);
    if (min_w < 75.0) $display("  narrowest phase %0t ns", min_w);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule